// File: doc/BRIEF.md
# Downspread Modulation Profile Generator

This block produces the slowly varying frequency-offset word that a fractional divider or numerically controlled oscillator uses to pull a synthesized clock below its nominal rate, so that emitted energy spreads over a band instead of sitting in one spectral line. The offset follows a triangle: it climbs one code at a time from zero to a programmed depth, falls back to zero, and repeats. Because the offset only subtracts from the nominal rate, the synthesized frequency never rises above nominal. The full-scale code of the offset word stands for a 0.6 % reduction, and larger depth settings are clipped to that full scale.

Spreading is requested by an active-low input that may change at any time; it passes through a synchronizer before it reaches the ramp. When the request is withdrawn the ramp keeps running until it next touches zero and only then stops, so the controlled clock never sees a step in frequency. The depth and the number of reference cycles each ramp code is held (the modulation-rate setting) are sampled while reset is asserted and stay fixed until the next reset. A system integrator picks the rate setting so that one triangle period, 2 × depth × hold cycles, falls in the 30 to 33 kHz band for the chosen depth and reference clock. The offset is meant for the processor-class and bus-class clock paths; reference and USB clocks are fed from an unmodulated path.

Top module: `dspread_gen`

## Requirements
- R1: While the synchronized request is inactive and the ramp is idle (including throughout reset and whenever `spread_n` has been high since reset), `freq_ofs` is 0 and `spread_on` is 0.
- R2: With the default unsigned output format, `freq_ofs` is the offset magnitude below nominal, its most significant bit is always 0, and its value never exceeds the clipped depth.
- R3: While spreading, successive values of the offset differ by at most one code, and every triangle reaches exactly the clipped depth at its peak and exactly 0 at its minimum.
- R4: Each offset code is held for S reference cycles, where S is the captured rate setting, or 1 when the setting is 0; the triangle period (from one 0-to-1 rise to the next) is 2 × depth × S cycles.
- R5: A depth setting above 4095 (the 12-bit full scale, 0.6 %) is clipped to 4095.
- R6: When the request is withdrawn, the ramp completes its current triangle down to 0 with no jump; `spread_on` falls in the same cycle the offset first reaches 0, and both then stay 0.
- R7: `depth_cfg` and `rate_cfg` are captured on every clock edge while `rst_n` is low; changes to them after reset is released have no effect.
- R8: A clipped depth of 0 keeps `freq_ofs` at 0 and `spread_on` at 0 even while spreading is requested.
- R9: `spread_n` passes through a two-stage synchronizer (reset value: inactive); after `spread_n` falls, `spread_on` is still 0 after two rising clock edges and is 1 after the third.
- R10: If the request is withdrawn and restored before the ramp reaches its minimum, the ramp passes through 0 and climbs again without `spread_on` ever dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset; settings are captured while low |
| spread_n | input | 1 | Asynchronous active-low spread request |
| depth_cfg | input | DEPTH_W (13) | Requested peak offset code, clipped to 4095 |
| rate_cfg | input | RATE_W (16) | Reference cycles each ramp code is held (0 treated as 1) |
| freq_ofs | output | OFS_W+1 (13) | Offset word: magnitude below nominal (unsigned) or its two's complement negative (signed variant) |
| spread_on | output | 1 | High while the ramp is running |

## Verification
A corrupted ramp state shows up at `freq_ofs` within one hold interval: a direction error produces a jump of more than one code or an overshoot past the depth, visible on the next step; a hold counter that runs long or short changes the dwell length of the very next code and, over a full triangle, the measured period. A wrongly kept or dropped request shows at the next profile minimum as a `spread_on` transition out of step with the offset reaching zero, or as a ramp that fails to climb again. Captured settings that drift after reset show as a changed peak or period in the following triangle.

// File: rtl/dspread_pkg.sv
`timescale 1ns/1ps
package dspread_pkg;

   // Direction of the triangular profile generator.
   typedef enum logic [1:0] {
      RAMP_IDLE = 2'd0,
      RAMP_UP   = 2'd1,
      RAMP_DOWN = 2'd2
   } ramp_state_e;

   // Output number formats selectable at the top.
   localparam int FMT_UNSIGNED = 0;
   localparam int FMT_SIGNED   = 1;

endpackage

// File: rtl/dspread_sync.sv
`timescale 1ns/1ps
module dspread_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   if (STAGES < 1) begin : g_bad_stages
      $error("dspread_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) chain_q <= RST_VAL;
         else        chain_q <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL}};
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/dspread_cfg.sv
`timescale 1ns/1ps
module dspread_cfg #(
   parameter int DEPTH_W = 13,
   parameter int OFS_W   = 12,
   parameter int RATE_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DEPTH_W-1:0] depth_in,
   input  logic [RATE_W-1:0]  rate_in,
   output logic [OFS_W-1:0]   depth_q,
   output logic [RATE_W-1:0]  hold_q
);

   logic [OFS_W-1:0]  depth_clip;
   logic [RATE_W-1:0] hold_clip;

   if (DEPTH_W < OFS_W) begin : g_bad_width
      $error("dspread_cfg: DEPTH_W must not be narrower than OFS_W");
   end else if (DEPTH_W == OFS_W) begin : g_no_clip
      assign depth_clip = depth_in;
   end else begin : g_clip
      localparam logic [DEPTH_W-1:0] FULL_EXT =
         {{(DEPTH_W-OFS_W){1'b0}}, {OFS_W{1'b1}}};
      assign depth_clip = (depth_in > FULL_EXT) ? {OFS_W{1'b1}}
                                                : depth_in[OFS_W-1:0];
   end

   // A zero hold count would stall the ramp; the shortest legal hold is one.
   assign hold_clip = (rate_in == '0) ? RATE_W'(1) : rate_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         depth_q <= depth_clip;
         hold_q  <= hold_clip;
      end
   end

   // R7: captured settings do not move once reset is released.
   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(depth_q) && $stable(hold_q)));

endmodule

// File: rtl/dspread_tick.sv
`timescale 1ns/1ps
module dspread_tick #(
   parameter int RATE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] hold_q,
   output logic              tick
);

   logic [RATE_W-1:0] cnt_q;

   assign tick = run && (cnt_q == hold_q - RATE_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + RATE_W'(1);
   end

   // R4: the dwell counter never runs past the captured hold length.
   assert_dwell_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < hold_q);

   // R4: an idle ramp keeps its dwell counter cleared.
   assert_dwell_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

endmodule

// File: rtl/dspread_ramp.sv
`timescale 1ns/1ps
module dspread_ramp
   import dspread_pkg::*;
#(
   parameter int OFS_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             tick,
   input  logic [OFS_W-1:0] depth_q,
   output logic [OFS_W-1:0] ofs_q,
   output logic             running
);

   ramp_state_e state_q;

   assign running = (state_q != RAMP_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RAMP_IDLE;
         ofs_q   <= '0;
      end else begin
         unique case (state_q)
            RAMP_IDLE: begin
               if (req && (depth_q != '0)) state_q <= RAMP_UP;
            end
            RAMP_UP: begin
               if (tick) begin
                  ofs_q <= ofs_q + OFS_W'(1);
                  if (ofs_q == depth_q - OFS_W'(1)) state_q <= RAMP_DOWN;
               end
            end
            RAMP_DOWN: begin
               if (tick) begin
                  ofs_q <= ofs_q - OFS_W'(1);
                  // Profile minimum: the only point where the request is honoured.
                  if (ofs_q == OFS_W'(1)) state_q <= req ? RAMP_UP : RAMP_IDLE;
               end
            end
            default: begin
               state_q <= RAMP_IDLE;
               ofs_q   <= '0;
            end
         endcase
      end
   end

   // R2: the offset never passes the programmed depth.
   assert_within_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_q <= depth_q);

   // R3: the offset moves by at most one code per cycle.
   assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ofs_q == $past(ofs_q)) ||
                (ofs_q == $past(ofs_q) + OFS_W'(1)) ||
                (ofs_q == $past(ofs_q) - OFS_W'(1))));

   // R1: an idle ramp holds a zero offset.
   assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RAMP_IDLE) |-> (ofs_q == '0));

   // R6: the ramp only stops from the last downward step with no request.
   assert_stop_at_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == RAMP_IDLE) && ($past(state_q) == RAMP_DOWN)) |->
         (($past(ofs_q) == OFS_W'(1)) && !$past(req)));

   // R8: a zero depth never starts the ramp.
   assert_zero_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_q == '0) |-> (state_q == RAMP_IDLE));

endmodule

// File: rtl/dspread_gen.sv
`timescale 1ns/1ps
module dspread_gen #(
   parameter int OFS_W       = 12,
   parameter int DEPTH_W     = 13,
   parameter int RATE_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int OUT_FMT     = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spread_n,
   input  logic [DEPTH_W-1:0] depth_cfg,
   input  logic [RATE_W-1:0]  rate_cfg,
   output logic [OFS_W:0]     freq_ofs,
   output logic               spread_on
);

   localparam int OUT_W = OFS_W + 1;

   if (OFS_W < 2) begin : g_bad_ofs
      $error("dspread_gen: OFS_W must be at least 2");
   end
   if (RATE_W < 1) begin : g_bad_rate
      $error("dspread_gen: RATE_W must be at least 1");
   end
   if ((OUT_FMT != dspread_pkg::FMT_UNSIGNED) && (OUT_FMT != dspread_pkg::FMT_SIGNED)) begin : g_bad_fmt
      $error("dspread_gen: OUT_FMT selects an unknown format");
   end

   logic              spread_n_s;
   logic              req;
   logic [OFS_W-1:0]  depth_q;
   logic [RATE_W-1:0] hold_q;
   logic              tick;
   logic              running;
   logic [OFS_W-1:0]  ofs;

   dspread_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (spread_n),
      .q     (spread_n_s)
   );

   assign req = ~spread_n_s;

   dspread_cfg #(
      .DEPTH_W (DEPTH_W),
      .OFS_W   (OFS_W),
      .RATE_W  (RATE_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .depth_in (depth_cfg),
      .rate_in  (rate_cfg),
      .depth_q  (depth_q),
      .hold_q   (hold_q)
   );

   dspread_tick #(
      .RATE_W (RATE_W)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (running),
      .hold_q (hold_q),
      .tick   (tick)
   );

   dspread_ramp #(
      .OFS_W (OFS_W)
   ) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .tick    (tick),
      .depth_q (depth_q),
      .ofs_q   (ofs),
      .running (running)
   );

   assign spread_on = running;

   if (OUT_FMT == dspread_pkg::FMT_SIGNED) begin : g_signed
      // Frequency delta as a negative two's complement number.
      assign freq_ofs = ~{1'b0, ofs} + OUT_W'(1);
   end else begin : g_unsigned
      assign freq_ofs = {1'b0, ofs};

      // R2: the unsigned magnitude never carries a sign bit.
      assert_no_upspread_R2: assert property (@(posedge clk) disable iff (!rst_n)
         freq_ofs[OFS_W] == 1'b0);
   end

   // R1: an inactive ramp presents a zero offset at the port.
   assert_off_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !spread_on |-> (freq_ofs == '0));

endmodule

// File: tb/dspread_gen_bench.sv
`timescale 1ns/1ps
module dspread_gen_bench;

   localparam int OFS_W   = 12;
   localparam int DEPTH_W = 13;
   localparam int RATE_W  = 16;
   localparam int CLK_NS  = 8;
   localparam int FULL    = 4095;

   logic               clk;
   logic               rst_n;
   logic               spread_n;
   logic [DEPTH_W-1:0] depth_cfg;
   logic [RATE_W-1:0]  rate_cfg;
   logic [OFS_W:0]     freq_ofs;
   logic               spread_on;

   int checks = 0;
   int errors = 0;

   dspread_gen #(
      .OFS_W   (OFS_W),
      .DEPTH_W (DEPTH_W),
      .RATE_W  (RATE_W)
   ) u_dspread_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .spread_n  (spread_n),
      .depth_cfg (depth_cfg),
      .rate_cfg  (rate_cfg),
      .freq_ofs  (freq_ofs),
      .spread_on (spread_on)
   );

   initial clk = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic restart(input int d, input int s, input bit sn);
      @(negedge clk);
      rst_n     = 1'b0;
      depth_cfg = DEPTH_W'(d);
      rate_cfg  = RATE_W'(s);
      spread_n  = sn;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic enable_and_wait();
      spread_n = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (spread_on) break;
      end
   endtask

   // Observe the offset for ncyc cycles; report peak, largest jump,
   // wrong dwell lengths, sign-bit hits and the 0-to-1 rise period.
   task automatic trace(input int ncyc, input int hold,
                        output int peak, output int jump, output int bad_dwell,
                        output int msb_hits, output int period);
      int prev  = -1;
      int dwell = 0;
      int seen  = 0;
      int ta    = -1;
      int tb    = -1;
      int v;
      peak = 0; jump = 0; bad_dwell = 0; msb_hits = 0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if (freq_ofs[OFS_W]) msb_hits++;
         v = int'(freq_ofs);
         if (v > peak) peak = v;
         if (prev >= 0 && v != prev) begin
            if ((v > prev ? v - prev : prev - v) > jump) jump = (v > prev ? v - prev : prev - v);
            if (seen != 0 && dwell != hold) bad_dwell++;
            seen = 1;
            dwell = 1;
            if (prev == 0) begin
               if (ta < 0) ta = i;
               else if (tb < 0) tb = i;
            end
         end else begin
            dwell++;
         end
         prev = v;
      end
      period = (tb >= 0) ? tb - ta : -1;
   endtask

   task automatic t_ramp(input int d, input int s, input string name);
      int deff = (d > FULL) ? FULL : d;
      int seff = (s == 0) ? 1 : s;
      int peak, jump, bad, msb, period;
      restart(d, s, 1'b1);
      enable_and_wait();
      trace(4 * deff * seff + 4 * seff + 10, seff, peak, jump, bad, msb, period);
      check(peak <= deff, {"R2 offset within depth ", name}, peak, deff);
      check(msb == 0, {"R2 sign bit clear ", name}, msb, 0);
      check(peak == deff, {"R3 peak equals depth ", name}, peak, deff);
      check(jump <= 1, {"R3 unit steps ", name}, jump, 1);
      check(bad == 0, {"R4 dwell per code ", name}, bad, 0);
      check(period == 2 * deff * seff, {"R4 triangle period ", name}, period, 2 * deff * seff);
   endtask

   task automatic t_reset_state();
      int bad = 0;
      @(negedge clk);
      rst_n = 1'b0; spread_n = 1'b0; depth_cfg = 13'd5; rate_cfg = 16'd1;
      repeat (4) begin
         @(negedge clk);
         if (freq_ofs != '0 || spread_on) bad++;
      end
      check(bad == 0, "R1 quiet during reset", bad, 0);
      restart(10, 2, 1'b1);
      bad = 0;
      repeat (60) begin
         @(negedge clk);
         if (freq_ofs != '0 || spread_on) bad++;
      end
      check(bad == 0, "R1 no spread while request high", bad, 0);
   endtask

   task automatic t_sync_latency();
      restart(3, 2, 1'b1);
      spread_n = 1'b0;
      repeat (2) @(negedge clk);
      check(spread_on == 1'b0, "R9 flag low after two edges", int'(spread_on), 0);
      @(negedge clk);
      check(spread_on == 1'b1, "R9 flag high after third edge", int'(spread_on), 1);
   endtask

   task automatic t_clip();
      int peak, jump, bad, msb, period;
      restart(FULL + 1000, 1, 1'b1);
      enable_and_wait();
      trace(2 * 2 * FULL + 20, 1, peak, jump, bad, msb, period);
      check(peak == FULL, "R5 depth clipped to full scale", peak, FULL);
      check(period == 2 * FULL, "R5 clipped period", period, 2 * FULL);
   endtask

   task automatic t_cfg_ignored();
      int peak, jump, bad, msb, period;
      restart(4, 2, 1'b1);
      depth_cfg = 13'd9;
      rate_cfg  = 16'd5;
      enable_and_wait();
      trace(60, 2, peak, jump, bad, msb, period);
      check(peak == 4, "R7 depth fixed after reset", peak, 4);
      check(period == 16, "R7 rate fixed after reset", period, 16);
   endtask

   task automatic t_depth_zero();
      int bad = 0;
      restart(0, 3, 1'b1);
      spread_n = 1'b0;
      repeat (50) begin
         @(negedge clk);
         if (freq_ofs != '0 || spread_on) bad++;
      end
      check(bad == 0, "R8 zero depth stays idle", bad, 0);
   endtask

   task automatic t_disable();
      int prev, v, jump = 0, peak = 0, early_off = 0, hit = 0, flag_at_zero = 1, bad_after = 0;
      restart(6, 2, 1'b1);
      enable_and_wait();
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (int'(freq_ofs) == 4) break;
      end
      spread_n = 1'b1;
      prev = int'(freq_ofs);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         v = int'(freq_ofs);
         if ((v > prev ? v - prev : prev - v) > jump) jump = (v > prev ? v - prev : prev - v);
         if (v > peak) peak = v;
         prev = v;
         if (v == 0) begin
            hit = 1;
            flag_at_zero = int'(spread_on);
            break;
         end
         if (!spread_on) early_off++;
      end
      repeat (40) begin
         @(negedge clk);
         if (freq_ofs != '0 || spread_on) bad_after++;
      end
      check(hit == 1, "R6 ramp returns to zero", hit, 1);
      check(jump <= 1, "R6 no jump while winding down", jump, 1);
      check(peak == 6, "R6 current triangle completed", peak, 6);
      check(early_off == 0, "R6 flag held until minimum", early_off, 0);
      check(flag_at_zero == 0, "R6 flag falls with zero offset", flag_at_zero, 0);
      check(bad_after == 0, "R6 stays stopped", bad_after, 0);
   endtask

   task automatic t_reenable();
      int off = 0, saw0 = 0, back = 0;
      restart(6, 2, 1'b1);
      enable_and_wait();
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (int'(freq_ofs) == 6) break;
      end
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (int'(freq_ofs) == 3) break;
      end
      spread_n = 1'b1;
      repeat (2) @(negedge clk);
      spread_n = 1'b0;
      repeat (60) begin
         @(negedge clk);
         if (!spread_on) off++;
         if (freq_ofs == '0) saw0 = 1;
         if (saw0 != 0 && int'(freq_ofs) == 6) back = 1;
      end
      check(off == 0, "R10 flag never drops", off, 0);
      check(back == 1, "R10 ramp climbs again", back, 1);
   endtask

   initial begin
      rst_n = 1'b0;
      spread_n = 1'b1;
      depth_cfg = '0;
      rate_cfg = 16'd1;
      t_reset_state();
      t_sync_latency();
      t_ramp(5, 3, "d5 s3");
      t_ramp(1, 4, "d1 s4");
      t_ramp(7, 0, "d7 s0");
      t_clip();
      t_cfg_ignored();
      t_depth_zero();
      t_disable();
      t_reenable();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule